// File: doc/BRIEF.md
# Read-Modify-Write Aware Port and Interrupt Flag Register

This block is a byte-wide peripheral register slave. It holds one general-purpose I/O port and one combined control and interrupt-flag register. The port has an output latch, a direction register and synchronized pin inputs. The flag register keeps pending interrupt requests that hardware events set, plus a few plain control bits stored above them.

A processor that sets or clears a single bit does so by reading a whole byte, changing one bit and writing the byte back. The bus marks the read half of that sequence with a read-modify-write indicator, and the read path changes its answer while the indicator is high. For the port it returns the output latch, not the pin levels, so a bit operation cannot copy an input pin level into a neighbouring latch bit. For the interrupt flags it returns all ones, so the write-back cannot clear a request that nobody meant to acknowledge. A flag clears only when a 0 is written to it.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read. Pin inputs pass through a parameterized synchronizer before the read path sees them.

Top module: `rmw_port_regs`

## Requirements
- R1: After reset, the read data, output latch, direction bits, pin outputs, pin output enables, interrupt flags and control bits are all 0.
- R2: A normal read (RMW indicator low) of the port register at address 0 returns the pin levels as synchronized over SYNC_STAGES cycles. The value appears on bus_rdata_o one cycle after the read strobe.
- R3: A read of the port register with the RMW indicator high returns the output latch contents, whatever the direction bits and pin levels are.
- R4: Writing address 1 loads the direction register. For each bit, pin_oe_o equals the direction bit, and pin_out_o equals the latch bit where the direction bit is 1 and 0 where it is 0.
- R5: A normal read of address 2 returns the pending interrupt flags in bits [NUM_FLAGS-1:0]. A 1 on event_i sets the matching flag, and irq_flag_o shows the flags.
- R6: A read of address 2 with the RMW indicator high returns 1 in every flag bit position [NUM_FLAGS-1:0].
- R7: Writing 0 to a flag bit at address 2 clears it, and writing 1 leaves it unchanged.
- R8: When an event and a write of 0 hit the same flag in the same cycle, the flag ends up set.
- R9: Bits [DATA_W-1:NUM_FLAGS] of address 2 are plain control bits. They are written directly and read back their stored value in both normal and RMW reads.
- R10: The direction register reads back its stored value at address 1 in both normal and RMW reads.
- R11: Address 3 reads as 0 in both read modes. A write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_rmw_i | input | 1 | Marks the read as part of a read-modify-write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| pin_i | input | DATA_W | Pin levels from the pads |
| pin_out_o | output | DATA_W | Output values to the pads |
| pin_oe_o | output | DATA_W | Per-pin output enables |
| event_i | input | NUM_FLAGS | Hardware events that set the flags |
| irq_flag_o | output | NUM_FLAGS | Pending interrupt flags |

## Verification
The port register is read with pin levels that differ from the latch and are then inverted. A normal read must follow the pins while an RMW read stays on the latch, which separates the two sources in both directions. The flag register is read with a mix of set and clear flags and nonzero control bits. This shows that the RMW read forces only the flag field, and that writing back the forced ones keeps the pending set. A write of 0 issued in the same cycle as an event tests the priority between software clear and hardware set, and an unused-address access confirms that nothing else moves.

// File: rtl/rmw_regs_pkg.sv
package rmw_regs_pkg;

  // Decoded register select; the code values match the bus address map.
  typedef enum logic [1:0] {
    SEL_PORT = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/rmw_pin_sync.sv
module rmw_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
          stage_q[0] <= async_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end

      assign sync_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rmw_port_bank.sv
module rmw_port_bank
  import rmw_regs_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o
);

  logic [WIDTH-1:0] latch_q, latch_nxt;
  logic [WIDTH-1:0] dir_q, dir_nxt;
  logic [WIDTH-1:0] pin_out_q, pin_oe_q;

  always_comb begin
    latch_nxt = latch_q;
    dir_nxt   = dir_q;
    if (wr_en && sel == SEL_PORT) latch_nxt = wdata;
    if (wr_en && sel == SEL_DIR)  dir_nxt   = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      dir_q     <= '0;
      pin_out_q <= '0;
      pin_oe_q  <= '0;
    end else begin
      latch_q   <= latch_nxt;
      dir_q     <= dir_nxt;
      pin_out_q <= latch_nxt & dir_nxt;
      pin_oe_q  <= dir_nxt;
    end
  end

  assign latch_o   = latch_q;
  assign dir_o     = dir_q;
  assign pin_out_o = pin_out_q;
  assign pin_oe_o  = pin_oe_q;

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DIR) |=> (pin_oe_o == $past(wdata))); // R4

  AST_INPUT_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    ((pin_out_o & ~pin_oe_o) == '0)); // R4

  AST_LATCH_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && sel == SEL_PORT)) |=> $stable(latch_o)); // R11

endmodule

// File: rtl/rmw_flag_bank.sv
module rmw_flag_bank
  import rmw_regs_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_FLAGS = 4,
  localparam int CTRL_W   = WIDTH - NUM_FLAGS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  reg_sel_e             sel,
  input  logic [WIDTH-1:0]     wdata,
  input  logic [NUM_FLAGS-1:0] event_i,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic [CTRL_W-1:0]    ctrl_o
);

  logic                 wr_hit;
  logic [NUM_FLAGS-1:0] wflag;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [CTRL_W-1:0]    ctrl_q;

  assign wr_hit = wr_en && (sel == SEL_FLAG);
  assign wflag  = wdata[NUM_FLAGS-1:0];

  // Each flag: a written 0 clears, a written 1 keeps, an event sets and wins.
  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic clr;
      assign clr = wr_hit && !wflag[i];

      always_ff @(posedge clk) begin
        if (rst) flag_q[i] <= 1'b0;
        else     flag_q[i] <= (flag_q[i] && !clr) || event_i[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= wdata[WIDTH-1:NUM_FLAGS];
  end

  assign flag_o = flag_q;
  assign ctrl_o = ctrl_q;

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|event_i) |=> ((flag_o & $past(event_i)) == $past(event_i))); // R8

  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> ((flag_o & $past(flag_o & wflag)) == $past(flag_o & wflag))); // R7

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> ((flag_o & $past(~wflag & ~event_i)) == '0)); // R7

  AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (ctrl_o == $past(wdata[WIDTH-1:NUM_FLAGS]))); // R9

endmodule

// File: rtl/rmw_read_path.sv
module rmw_read_path
  import rmw_regs_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_FLAGS = 4,
  localparam int CTRL_W   = WIDTH - NUM_FLAGS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 rmw,
  input  reg_sel_e             sel,
  input  logic [WIDTH-1:0]     pin_lvl,
  input  logic [WIDTH-1:0]     latch,
  input  logic [WIDTH-1:0]     dir,
  input  logic [NUM_FLAGS-1:0] flag,
  input  logic [CTRL_W-1:0]    ctrl,
  output logic [WIDTH-1:0]     rdata_o
);

  logic [WIDTH-1:0] rd_nxt;
  logic [WIDTH-1:0] rdata_q;

  always_comb begin
    unique case (sel)
      SEL_PORT: rd_nxt = rmw ? latch : pin_lvl;
      SEL_DIR:  rd_nxt = dir;
      SEL_FLAG: rd_nxt = {ctrl, (rmw ? {NUM_FLAGS{1'b1}} : flag)};
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end

  assign rdata_o = rdata_q;

  AST_RMW_PORT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rmw && sel == SEL_PORT) |=> (rdata_o == $past(latch))); // R3

  AST_RMW_FLAGS_ONE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rmw && sel == SEL_FLAG) |=> (&rdata_o[NUM_FLAGS-1:0])); // R6

  AST_CTRL_BOTH_MODES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_FLAG) |=> (rdata_o[WIDTH-1:NUM_FLAGS] == $past(ctrl))); // R9

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> (rdata_o == '0)); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rdata_o)); // R2

endmodule

// File: rtl/rmw_port_regs.sv
module rmw_port_regs
  import rmw_regs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int NUM_FLAGS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_rd_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rmw_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  input  logic [DATA_W-1:0]    pin_i,
  output logic [DATA_W-1:0]    pin_out_o,
  output logic [DATA_W-1:0]    pin_oe_o,
  input  logic [NUM_FLAGS-1:0] event_i,
  output logic [NUM_FLAGS-1:0] irq_flag_o
);

  localparam int CTRL_W = DATA_W - NUM_FLAGS;

  reg_sel_e            sel;
  logic [DATA_W-1:0]   pin_lvl;
  logic [DATA_W-1:0]   latch;
  logic [DATA_W-1:0]   dir;
  logic [NUM_FLAGS-1:0] flag;
  logic [CTRL_W-1:0]   ctrl;

  // Address decode: addresses above the register map select nothing.
  always_comb begin
    unique case (bus_addr_i)
      ADDR_W'(0): sel = SEL_PORT;
      ADDR_W'(1): sel = SEL_DIR;
      ADDR_W'(2): sel = SEL_FLAG;
      default:    sel = SEL_NONE;
    endcase
  end

  rmw_pin_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_i),
    .sync_o  (pin_lvl)
  );

  rmw_port_bank #(.WIDTH(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr_i),
    .sel       (sel),
    .wdata     (bus_wdata_i),
    .latch_o   (latch),
    .dir_o     (dir),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );

  rmw_flag_bank #(.WIDTH(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_flag (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr_i),
    .sel     (sel),
    .wdata   (bus_wdata_i),
    .event_i (event_i),
    .flag_o  (flag),
    .ctrl_o  (ctrl)
  );

  rmw_read_path #(.WIDTH(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd_i),
    .rmw     (bus_rmw_i),
    .sel     (sel),
    .pin_lvl (pin_lvl),
    .latch   (latch),
    .dir     (dir),
    .flag    (flag),
    .ctrl    (ctrl),
    .rdata_o (bus_rdata_o)
  );

  assign irq_flag_o = flag;

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!(bus_wr_i && bus_addr_i == ADDR_W'(1))) |=> $stable(pin_oe_o)); // R11

  AST_NORMAL_FLAG_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && !bus_rmw_i && bus_addr_i == ADDR_W'(2))
      |=> (bus_rdata_o[NUM_FLAGS-1:0] == $past(irq_flag_o))); // R5

endmodule

// File: tb/rmw_port_regs_test.sv
module rmw_port_regs_test;

  localparam int DW = 8;
  localparam int AW = 2;
  localparam int NF = 4;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr_i = '0;
  logic          bus_rd_i = 1'b0;
  logic          bus_wr_i = 1'b0;
  logic          bus_rmw_i = 1'b0;
  logic [DW-1:0] bus_wdata_i = '0;
  logic [DW-1:0] bus_rdata_o;
  logic [DW-1:0] pin_i = '0;
  logic [DW-1:0] pin_out_o;
  logic [DW-1:0] pin_oe_o;
  logic [NF-1:0] event_i = '0;
  logic [NF-1:0] irq_flag_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rmw_port_regs #(.DATA_W(DW), .ADDR_W(AW), .NUM_FLAGS(NF), .SYNC_STAGES(SS)) uut (
    .clk (clk), .rst (rst),
    .bus_addr_i (bus_addr_i), .bus_rd_i (bus_rd_i), .bus_wr_i (bus_wr_i),
    .bus_rmw_i (bus_rmw_i), .bus_wdata_i (bus_wdata_i), .bus_rdata_o (bus_rdata_o),
    .pin_i (pin_i), .pin_out_o (pin_out_o), .pin_oe_o (pin_oe_o),
    .event_i (event_i), .irq_flag_o (irq_flag_o)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [NF-1:0] ev = '0);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1; event_i = ev;
    @(negedge clk);
    bus_wr_i = 1'b0; event_i = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic rmw, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_rmw_i = rmw; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0; bus_rmw_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic pulse_event(input logic [NF-1:0] ev);
    @(negedge clk);
    event_i = ev;
    @(negedge clk);
    event_i = '0;
  endtask

  task automatic set_pins(input logic [DW-1:0] p);
    @(negedge clk);
    pin_i = p;
    repeat (SS + 1) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "rdata", bus_rdata_o, 8'h00);
    check("R1", "pin_out", pin_out_o, 8'h00);
    check("R1", "pin_oe", pin_oe_o, 8'h00);
    check("R1", "flags", DW'(irq_flag_o), 8'h00);
  endtask

  task automatic t_direction;
    logic [DW-1:0] d;
    bus_write(2'd1, 8'hF0);
    bus_write(2'd0, 8'hA5);
    check("R4", "pin_oe", pin_oe_o, 8'hF0);
    check("R4", "pin_out", pin_out_o, 8'hA0);
    bus_read(2'd1, 1'b0, d); check("R10", "dir normal", d, 8'hF0);
    bus_read(2'd1, 1'b1, d); check("R10", "dir rmw", d, 8'hF0);
  endtask

  task automatic t_port_reads;
    logic [DW-1:0] d;
    set_pins(8'h3C);
    bus_read(2'd0, 1'b0, d); check("R2", "pins 3C", d, 8'h3C);
    set_pins(8'hC3);
    bus_read(2'd0, 1'b0, d); check("R2", "pins C3", d, 8'hC3);
    set_pins(8'h00);
    bus_read(2'd0, 1'b1, d); check("R3", "rmw pins 00", d, 8'hA5);
    set_pins(8'hFF);
    bus_read(2'd0, 1'b1, d); check("R3", "rmw pins FF", d, 8'hA5);
    // bit-set sequence on bit 1 while all pins read high
    bus_read(2'd0, 1'b1, d);
    bus_write(2'd0, d | 8'h02);
    bus_read(2'd0, 1'b1, d); check("R3", "latch after bit set", d, 8'hA7);
    check("R4", "pin_out after bit set", pin_out_o, 8'hA0);
  endtask

  task automatic t_flags;
    logic [DW-1:0] d;
    pulse_event(4'b0101);
    check("R5", "irq_flag", DW'(irq_flag_o), 8'h05);
    bus_read(2'd2, 1'b0, d); check("R5", "flag normal", d, 8'h05);
    bus_read(2'd2, 1'b1, d); check("R6", "flag rmw", d, 8'h0F);
    bus_write(2'd2, d);
    check("R7", "write-back keeps", DW'(irq_flag_o), 8'h05);
    bus_write(2'd2, 8'h0E);
    check("R7", "clear bit0", DW'(irq_flag_o), 8'h04);
  endtask

  task automatic t_race;
    bus_write(2'd2, 8'h00, 4'b0010);
    check("R8", "event beats clear", DW'(irq_flag_o), 8'h02);
    bus_write(2'd2, 8'h00, 4'b0000);
    check("R7", "clear all", DW'(irq_flag_o), 8'h00);
  endtask

  task automatic t_ctrl;
    logic [DW-1:0] d;
    bus_write(2'd2, 8'hA0);
    pulse_event(4'b1000);
    bus_read(2'd2, 1'b0, d); check("R9", "ctrl normal", d, 8'hA8);
    bus_read(2'd2, 1'b1, d); check("R9", "ctrl rmw", d, 8'hAF);
  endtask

  task automatic t_unused;
    logic [DW-1:0] d;
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, 1'b0, d); check("R11", "unused normal", d, 8'h00);
    bus_read(2'd3, 1'b1, d); check("R11", "unused rmw", d, 8'h00);
    bus_read(2'd0, 1'b1, d); check("R11", "latch kept", d, 8'hA7);
    bus_read(2'd1, 1'b0, d); check("R11", "dir kept", d, 8'hF0);
    bus_read(2'd2, 1'b0, d); check("R11", "flag reg kept", d, 8'hA8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direction();
    t_port_reads();
    t_flags();
    t_race();
    t_ctrl();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule